// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Timer Bank

This block holds a bank of prescaled 64-bit down-counters behind a small memory-mapped register port. Any counter can be chosen as the system watchdog. A neighbouring counter can feed it a restart event, so software can keep the watchdog alive without ever switching it off.

Each counter has a control word and a 64-bit initial (reload) value, written as two 32-bit halves. In one-shot mode a counter loads its reload value when it is enabled and counts down to zero. In hardware-signal mode a counter waits for a trigger event and reloads on every trigger. The trigger can be the end-count pulse of the counter one index below.

Keep-alive works like this. A one-shot counter with a reload value of zero raises an end-count pulse as soon as its enable bit goes from 0 to 1. That pulse reloads the watchdog counter above it. A read of a counter's low count word also captures its high word, so software can read the 64-bit value coherently even while it is counting.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0, `end_pulse` is 0 and `wdog_expired` is 0.
- R2: Counter i occupies byte addresses i*0x10 (control), i*0x10+4 (low count) and i*0x10+8 (high count). The watchdog select register is at 0x40. All other addresses read 0.
- R3: The control word has the following fields:
  - bit 0: enable.
  - bit 1: active status, read-only; writes to it are ignored.
  - bits 3:2: mode. 11 is hardware-signal mode; any other value acts as one-shot.
  - bits 7:4: trigger source.
  - bits 15:8: prescaler.
  - bits 31:16: read 0.
- R4: An active counter decrements once every P clock cycles, where P is the prescaler field. Values 0 and 1 act as 2. The first decrement comes P cycles after the load.
- R5: Writing the low and high count words changes only the reload value, never the live count. A low-count read returns the live count bits 31:0.
- R6: In one-shot mode, a 0-to-1 write of enable loads the reload value and makes the counter active. When the count reaches 0, `end_pulse[i]` is high for exactly the next cycle, active clears and the count stays 0.
- R7: Loading a reload value of 0 gives an end pulse in the cycle after the load without going active. Clearing and then setting enable again repeats the pulse.
- R8: In hardware-signal mode, enabling does not start the counter. With trigger source 5, an end pulse of counter i-1 reloads counter i, also while it is running. Any other trigger source never reloads it, and counter 0 has no previous counter.
- R9: A read of a low count word captures that counter's high count bits. A later read of the high word returns the captured bits, not the live ones.
- R10: Clearing enable stops the counter and clears active in the same edge. The live count holds its value.
- R11: The select register is a 4-bit one-hot mask. An end pulse from a selected, enabled counter sets `wdog_expired` one cycle later. It stays set until reset. A mask of 0 selects no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a low-word read captures the high word) |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| end_pulse | output | 4 | One-cycle end-count pulse of each counter |
| wdog_expired | output | 1 | Sticky watchdog expiry |

## Verification
The bench targets the following cases:

- **Zero-reload one-shot counter.** It must pulse at once and stay inactive. A design that went active would hold the counter for a wrap-around of 2^64 prescaled steps, and pinging would never work.
- **Borrow across bit 32 during a split read.** A design without the capture would return a torn value.
- **Hardware-signal counter with a trigger source other than 5.** A design that decoded the source loosely would reload it from its neighbour by accident.
- **Repeated pings just before expiry, and an unselected counter reaching zero.** These catch a watchdog that is armed by any counter, and one that misses the chained reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] MODE_HWSIG = 2'b11;
  localparam logic [3:0] TRIG_PREV  = 4'h5;

  typedef struct packed {
    logic [7:0] presc;
    logic [3:0] trig;
    logic [1:0] mode;
    logic       en;
  } ctrl_t;

  // prescale divide factor, values below 2 act as 2
  function automatic logic [8:0] eff_div(input logic [7:0] p);
    return (p < 8'd2) ? 9'd2 : {1'b0, p};
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.presc = w[15:8];
    c.trig  = w[7:4];
    c.mode  = w[3:2];
    c.en    = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c, input logic act);
    return {16'h0, c.presc, c.trig, c.mode, act, c.en};
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [31:0]      wdata,
  input  logic             prev_end,
  output ctrl_t            ctrl_q,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output logic             end_evt
);
  localparam int HI_W = CNT_W - 32;

  ctrl_t            ctrl_n;
  logic [CNT_W-1:0] reload;
  logic [7:0]       pcnt;
  logic             en_rise, trig_hit, tick, load_evt;

  assign ctrl_n   = ctrl_we ? ctrl_from_word(wdata) : ctrl_q;
  assign en_rise  = ctrl_we && wdata[0] && !ctrl_q.en;
  assign trig_hit = (ctrl_n.mode == MODE_HWSIG) && (ctrl_n.trig == TRIG_PREV) && prev_end;
  assign load_evt = ctrl_n.en && ((en_rise && ctrl_n.mode != MODE_HWSIG) || trig_hit);
  assign tick     = active && ({1'b0, pcnt} == eff_div(ctrl_q.presc) - 9'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      reload  <= '0;
      count   <= '0;
      pcnt    <= '0;
      active  <= 1'b0;
      end_evt <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_n;
      if (lo_we) reload[31:0] <= wdata;
      if (hi_we) reload[CNT_W-1:32] <= wdata[HI_W-1:0];
      end_evt <= 1'b0;
      if (!ctrl_n.en) begin
        active <= 1'b0;
        pcnt   <= '0;
      end else if (load_evt) begin
        pcnt  <= '0;
        count <= reload;
        if (reload == '0) begin
          active  <= 1'b0;
          end_evt <= 1'b1;
        end else begin
          active <= 1'b1;
        end
      end else if (active) begin
        if (tick) begin
          pcnt  <= '0;
          count <= count - 1'b1;
          if (count == CNT_W'(1)) begin
            active  <= 1'b0;
            end_evt <= 1'b1;
          end
        end else begin
          pcnt <= pcnt + 8'd1;
        end
      end
    end
  end

  // R6: an active counter never rests at zero
  p_active_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (count != '0));
  // R6: an end pulse lasts a single cycle
  p_end_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !end_evt);
  // R10: a disabled counter is never active
  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> !active);
  // R4: between loads the count moves by at most one step
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(load_evt)) |->
      ((count == $past(count)) || (count == $past(count) - 1'b1)));
  // R8: a counter only becomes active through a load
  p_start_by_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(load_evt));
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
  parameter int NCNT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [NCNT-1:0] sel_wdata,
  input  logic [NCNT-1:0] end_vec,
  input  logic [NCNT-1:0] en_vec,
  output logic [NCNT-1:0] sel_q,
  output logic            expired
);
  logic fire;
  assign fire = |(sel_q & end_vec & en_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      expired <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (fire) expired <= 1'b1;
    end
  end

  // R11: expiry is sticky
  p_expired_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);
  // R11: expiry needs a selected, enabled counter ending
  p_expire_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(|(sel_q & end_vec & en_vec)));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCNT   = 4,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCNT-1:0]   end_pulse,
  output logic              wdog_expired
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam int HI_W   = CNT_W - 32;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NCNT * 16);

  ctrl_t            ctrl_v [NCNT];
  logic [CNT_W-1:0] cnt_v  [NCNT];
  logic [HI_W-1:0]  hold_v [NCNT];
  logic [NCNT-1:0]  act_vec, en_vec, end_vec, prev_vec, sel_q;
  logic [SLOT_W-1:0] slot;
  logic [3:0]        off;

  assign slot      = addr[ADDR_W-1:4];
  assign off       = addr[3:0];
  assign prev_vec  = {end_vec[NCNT-2:0], 1'b0};
  assign end_pulse = end_vec;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic hit, rd_lo;
    assign hit       = (slot == SLOT_W'(i));
    assign rd_lo     = rd_en && hit && (off == 4'h4);
    assign en_vec[i] = ctrl_v[i].en;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (wr_en && hit && (off == 4'h0)),
      .lo_we    (wr_en && hit && (off == 4'h4)),
      .hi_we    (wr_en && hit && (off == 4'h8)),
      .wdata    (wdata),
      .prev_end (prev_vec[i]),
      .ctrl_q   (ctrl_v[i]),
      .active   (act_vec[i]),
      .count    (cnt_v[i]),
      .end_evt  (end_vec[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) hold_v[i] <= '0;
      else if (rd_lo) hold_v[i] <= cnt_v[i][CNT_W-1:32];
    end

    // R9: the captured half matches the live high bits at the low read
    p_hold_coherent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> (hold_v[i] == $past(cnt_v[i][CNT_W-1:32])));
  end

  tmr_wdog #(.NCNT(NCNT)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (wr_en && (addr == SEL_ADDR)),
    .sel_wdata (wdata[NCNT-1:0]),
    .end_vec   (end_vec),
    .en_vec    (en_vec),
    .sel_q     (sel_q),
    .expired   (wdog_expired)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (slot == SLOT_W'(i)) begin
        case (off)
          4'h0:    rdata = ctrl_to_word(ctrl_v[i], act_vec[i]);
          4'h4:    rdata = cnt_v[i][31:0];
          4'h8:    rdata = 32'(hold_v[i]);
          default: rdata = '0;
        endcase
      end
    end
    if (addr == SEL_ADDR) rdata = 32'(sel_q);
  end
endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  end_pulse;
  logic        wdog_expired;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit          m_en[4], m_act[4], m_end[4];
  bit [1:0]    m_mode[4];
  bit [3:0]    m_trig[4];
  bit [7:0]    m_presc[4];
  longint unsigned m_reload[4], m_count[4];
  int          m_pc[4];
  bit [31:0]   m_hold[4];
  bit [3:0]    m_sel;
  bit          m_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .end_pulse(end_pulse), .wdog_expired(wdog_expired)
  );

  function automatic bit [31:0] model_read(bit [7:0] a);
    int s = a / 16;
    if (a == 8'h40) return {28'h0, m_sel};
    if (s > 3) return 0;
    case (a % 16)
      0: return {16'h0, m_presc[s], m_trig[s], m_mode[s], m_act[s], m_en[s]};
      4: return m_count[s][31:0];
      8: return m_hold[s];
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 0; m_act[i] = 0; m_end[i] = 0; m_mode[i] = 0; m_trig[i] = 0;
      m_presc[i] = 0; m_reload[i] = 0; m_count[i] = 0; m_pc[i] = 0; m_hold[i] = 0;
    end
    m_sel = 0; m_exp = 0;
  endtask

  task automatic model_edge(bit w, bit r, bit [7:0] a, bit [31:0] d);
    bit old_end[4];
    for (int i = 0; i < 4; i++) old_end[i] = m_end[i];
    for (int i = 0; i < 4; i++) if (old_end[i] && m_en[i] && m_sel[i]) m_exp = 1;
    if (w && a == 8'h40) m_sel = d[3:0];
    for (int i = 0; i < 4; i++) if (r && a == 8'(i*16+4)) m_hold[i] = m_count[i][63:32];
    for (int i = 0; i < 4; i++) begin
      bit we = w && (a == 8'(i*16));
      bit nen = we ? d[0] : m_en[i];
      bit [1:0] nmode = we ? d[3:2] : m_mode[i];
      bit [3:0] ntrig = we ? d[7:4] : m_trig[i];
      bit prev = (i > 0) ? old_end[i-1] : 1'b0;
      bit hit = (nmode == 2'b11) && (ntrig == 4'h5) && prev;
      bit rise = we && d[0] && !m_en[i];
      int div = (m_presc[i] < 2) ? 2 : int'(m_presc[i]);
      bit ne = 0;
      if (!nen) begin
        m_act[i] = 0; m_pc[i] = 0;
      end else if ((rise && nmode != 2'b11) || hit) begin
        m_pc[i] = 0; m_count[i] = m_reload[i];
        if (m_reload[i] == 0) begin m_act[i] = 0; ne = 1; end
        else m_act[i] = 1;
      end else if (m_act[i]) begin
        m_pc[i]++;
        if (m_pc[i] == div) begin
          m_pc[i] = 0; m_count[i]--;
          if (m_count[i] == 0) begin m_act[i] = 0; ne = 1; end
        end
      end
      m_end[i] = ne;
      if (we) begin
        m_en[i] = d[0]; m_mode[i] = d[3:2]; m_trig[i] = d[7:4]; m_presc[i] = d[15:8];
      end
      if (w && a == 8'(i*16+4)) m_reload[i][31:0] = d;
      if (w && a == 8'(i*16+8)) m_reload[i][63:32] = d;
    end
  endtask

  task automatic step(bit w, bit r, bit [7:0] a, bit [31:0] d, string tag);
    bit [3:0] exp_end;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) begin
      vectors++;
      if (rdata !== model_read(a)) begin
        errors++;
        $display("FAIL %s read @%h: got %h expected %h", tag, a, rdata, model_read(a));
      end
    end
    @(posedge clk);
    model_edge(w, r, a, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    exp_end = {m_end[3], m_end[2], m_end[1], m_end[0]};
    vectors++;
    if (end_pulse !== exp_end || wdog_expired !== m_exp) begin
      errors++;
      $display("FAIL %s outputs: got end=%b exp=%b expected end=%b exp=%b",
               tag, end_pulse, wdog_expired, exp_end, m_exp);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(0, 0, 8'h0, 0, tag);
  endtask

  task automatic rd(bit [7:0] a, string tag);
    step(0, 1, a, 0, tag);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, string tag);
    step(1, 0, a, d, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2: reset values everywhere
    for (int a = 0; a < 80; a += 4) rd(8'(a), "R1");
    rd(8'h4c, "R2");
    // R3: read-only active bit ignored on write
    wr(8'h30, 32'h0000_0002, "R3");
    rd(8'h30, "R3");
    // R5 / R6 / R4: one-shot counter 2, prescale 3, sel=0 so no expiry (R11)
    wr(8'h24, 32'd5, "R5");
    rd(8'h24, "R5");
    wr(8'h20, 32'h0000_0301, "R6");
    rd(8'h20, "R3");
    idle(20, "R4");
    rd(8'h20, "R6");
    rd(8'h24, "R6");
    // R4: prescale field 0 acts as 2
    wr(8'h20, 32'h0, "R10");
    wr(8'h24, 32'd3, "R5");
    wr(8'h20, 32'h0000_0001, "R4");
    idle(9, "R4");
    // R7: zero-reload one-shot on counter 0, toggled twice
    wr(8'h00, 32'h0000_0201, "R7");
    idle(2, "R7");
    rd(8'h00, "R7");
    wr(8'h00, 32'h0000_0200, "R7");
    wr(8'h00, 32'h0000_0201, "R7");
    idle(2, "R7");
    // R9: coherent read across a borrow, then R10 disable holds count
    wr(8'h34, 32'd1, "R9");
    wr(8'h38, 32'd1, "R9");
    wr(8'h30, 32'h0000_0201, "R9");
    rd(8'h34, "R9");
    idle(6, "R9");
    rd(8'h38, "R9");
    rd(8'h34, "R9");
    rd(8'h38, "R9");
    wr(8'h30, 32'h0000_0200, "R10");
    rd(8'h30, "R10");
    rd(8'h34, "R10");
    idle(5, "R10");
    rd(8'h34, "R10");
    // R8: counter 2 in hw mode with trigger source 3 must ignore counter 1
    wr(8'h24, 32'd4, "R8");
    wr(8'h20, 32'h0000_023d, "R8");
    // R8 / R11: watchdog on counter 1 fed by counter 0
    wr(8'h40, 32'h2, "R11");
    rd(8'h40, "R11");
    wr(8'h14, 32'd10, "R8");
    wr(8'h10, 32'h0000_025d, "R8");
    idle(5, "R8");
    rd(8'h10, "R8");
    wr(8'h00, 32'h0000_0200, "R8");
    wr(8'h00, 32'h0000_0201, "R8");
    idle(2, "R8");
    rd(8'h10, "R8");
    for (int p = 0; p < 3; p++) begin
      idle(12, "R8");
      wr(8'h00, 32'h0000_0200, "R8");
      wr(8'h00, 32'h0000_0201, "R8");
    end
    idle(30, "R11");
    rd(8'h20, "R8");
    rd(8'h24, "R8");
    wr(8'h10, 32'h0000_025c, "R11");
    idle(3, "R11");
    // R1: reset clears the expiry
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");
    rd(8'h10, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule